// File: doc/BRIEF.md
# Sleep State Power Sequencer

This controller steps a platform through its wake and shutdown orders. It drives three active-low sleep-level enables (deepest, middle, lightest), a suspend-status output, a platform reset, a processor power-good and a clock-valid flag. Each step waits a minimum number of 1 µs timing ticks after the step before it. Every delay is a parameter counted in those ticks.

On a wake request the controller releases whichever sleep enables are still asserted, deepest first. It then waits for the raw power-good input to pass a deglitch filter. It marks clocks valid and raises processor power-good, waits for system power-good, then releases suspend-status and after that the platform reset. On a sleep request with a target depth, it waits for link idle, then runs the shutdown order. That order asserts suspend-status, asserts reset, drops processor power-good, invalidates clocks, and then asserts sleep enables from lightest to deepest. It stops at the depth that was requested.

Top module: `sleep_seq`

## Requirements
- R1: After reset all three sleep enables are low, suspend-status and platform reset are low, processor power-good and clock-valid are low, and the block rests at full off.
- R2: A wake request in the resting state releases the deepest asserted sleep enable at the next clock edge. The remaining asserted enables are released from deeper to lighter.
- R3: Each further sleep-enable release on wake, and each sleep-enable assertion after the lightest on shutdown, takes effect at the clock edge that samples the T_SLP-th tick after the previous one. In general, a timed step takes effect on the edge that samples the N-th tick strobe after the edge of the previous step.
- R4: Raw power-good counts as good only after it has been high for T_DEGL consecutive ticks with the lightest enable released. A low sample restarts the count, and an asserted lightest enable holds the count at zero.
- R5: T_CLK ticks after the deglitched power-good is accepted, clock-valid and processor power-good rise together.
- R6: Suspend-status is released T_SUS ticks after processor power-good and system power-good are both high. If system power-good falls during that wait, the count restarts.
- R7: Platform reset is released T_PLT ticks after suspend-status is released. This completes the wake.
- R8: A sleep request while fully awake waits for link idle, and then asserts suspend-status T_IDLE ticks later.
- R9: On shutdown, platform reset is asserted T_SUSRST ticks after suspend-status. Processor power-good drops T_PGOFF ticks after that, clock-valid drops T_CLKOFF ticks after that, and the lightest enable is asserted T_LIGHT ticks after that.
- R10: The sleep depth (2-bit: 0 or 1 lightest, 2 middle, 3 full off) is captured with the sleep request. The shutdown stops after asserting the lightest enable, the middle enable, or all three enables, according to that depth.
- R11: A wake request seen during the shutdown order is held. The wake starts once the shutdown order has finished.
- R12: A wake resumes from the depth reached. Released enables stay released, and the first asserted enable is released at the next edge.
- R13: A sleep request outside the fully-awake state is ignored. A wake request outside the resting and shutdown states is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| wake_req | input | 1 | Wake request |
| sleep_req | input | 1 | Sleep request |
| sleep_depth | input | 2 | Target depth, captured with sleep_req |
| links_idle | input | 1 | All links report idle |
| pwrok_raw | input | 1 | Undeglitched power-good |
| sys_pwrok | input | 1 | System power-good |
| slp_deep_n | output | 1 | Deepest sleep enable, active low |
| slp_mid_n | output | 1 | Middle sleep enable, active low |
| slp_light_n | output | 1 | Lightest sleep enable, active low |
| sus_stat_n | output | 1 | Suspend-status, active low |
| plt_rst_n | output | 1 | Platform reset, active low |
| cpu_pwrgd | output | 1 | Processor power-good |
| clk_valid | output | 1 | Clock outputs stable |

## Verification
The ordering properties assume that the tick strobe lasts one clock cycle. They also assume that system power-good, once high during a wake, stays high until suspend-status is released. The stimulus holds system power-good steady once it has been raised, and produces ticks from a fixed divider. It pulses the request inputs for one cycle each, driven between clock edges. The deglitch glitch is a single low cycle, so the filter restart is exercised without breaking those assumptions.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int T_SLP    = 30,
  parameter int T_DEGL   = 1000,
  parameter int T_CLK    = 1000,
  parameter int T_SUS    = 1000,
  parameter int T_PLT    = 60,
  parameter int T_IDLE   = 60,
  parameter int T_SUSRST = 210,
  parameter int T_PGOFF  = 30,
  parameter int T_CLKOFF = 10,
  parameter int T_LIGHT  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       wake_req,
  input  logic       sleep_req,
  input  logic [1:0] sleep_depth,
  input  logic       links_idle,
  input  logic       pwrok_raw,
  input  logic       sys_pwrok,
  output logic       slp_deep_n,
  output logic       slp_mid_n,
  output logic       slp_light_n,
  output logic       sus_stat_n,
  output logic       plt_rst_n,
  output logic       cpu_pwrgd,
  output logic       clk_valid
);
  localparam int TSUM = T_SLP + T_CLK + T_SUS + T_PLT + T_IDLE + T_SUSRST + T_PGOFF + T_CLKOFF + T_LIGHT;
  localparam int CW = $clog2(TSUM + 1);
  localparam int GW = $clog2(T_DEGL + 1);

  typedef enum logic [4:0] {
    S_REST, W_MID, W_LIGHT, W_PG, W_CLK, W_SYS, W_SUS, W_RST, S_ON,
    D_IDLE, D_SUS, D_RST, D_PG, D_CLK, D_LIGHT, D_MID, D_DEEP
  } st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt, lim;
  logic [GW-1:0] pg_cnt;
  logic [1:0] depth;
  logic wake_pend;

  wire pg_ok = (pg_cnt == GW'(T_DEGL));
  wire go = wake_req | wake_pend;
  wire timed = (lim != '0);
  wire hit = tick_us && timed && (cnt == lim - 1'b1);
  wire in_down = (st >= D_IDLE);

  always_comb begin
    case (st)
      W_MID, W_LIGHT, D_MID, D_DEEP: lim = CW'(T_SLP);
      W_CLK:   lim = CW'(T_CLK);
      W_SUS:   lim = CW'(T_SUS);
      W_RST:   lim = CW'(T_PLT);
      D_SUS:   lim = CW'(T_IDLE);
      D_RST:   lim = CW'(T_SUSRST);
      D_PG:    lim = CW'(T_PGOFF);
      D_CLK:   lim = CW'(T_CLKOFF);
      D_LIGHT: lim = CW'(T_LIGHT);
      default: lim = '0;
    endcase
  end

  always_comb begin
    st_n = st;
    case (st)
      S_REST:  if (go) st_n = !slp_deep_n ? W_MID : (!slp_mid_n ? W_LIGHT : W_PG);
      W_MID:   if (hit) st_n = W_LIGHT;
      W_LIGHT: if (hit) st_n = W_PG;
      W_PG:    if (pg_ok) st_n = W_CLK;
      W_CLK:   if (hit) st_n = W_SYS;
      W_SYS:   if (sys_pwrok) st_n = W_SUS;
      W_SUS:   if (!sys_pwrok) st_n = W_SYS; else if (hit) st_n = W_RST;
      W_RST:   if (hit) st_n = S_ON;
      S_ON:    if (sleep_req) st_n = D_IDLE;
      D_IDLE:  if (links_idle) st_n = D_SUS;
      D_SUS:   if (hit) st_n = D_RST;
      D_RST:   if (hit) st_n = D_PG;
      D_PG:    if (hit) st_n = D_CLK;
      D_CLK:   if (hit) st_n = D_LIGHT;
      D_LIGHT: if (hit) st_n = (depth < 2'd2) ? S_REST : D_MID;
      D_MID:   if (hit) st_n = (depth == 2'd2) ? S_REST : D_DEEP;
      D_DEEP:  if (hit) st_n = S_REST;
      default: st_n = S_REST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_cnt <= '0;
    end else if (!pwrok_raw || !slp_light_n) begin
      pg_cnt <= '0;
    end else if (tick_us && !pg_ok) begin
      pg_cnt <= pg_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_REST;
      cnt <= '0;
      depth <= 2'd3;
      wake_pend <= 1'b0;
      slp_deep_n <= 1'b0;
      slp_mid_n <= 1'b0;
      slp_light_n <= 1'b0;
      sus_stat_n <= 1'b0;
      plt_rst_n <= 1'b0;
      cpu_pwrgd <= 1'b0;
      clk_valid <= 1'b0;
    end else begin
      st <= st_n;
      if (st_n != st || !timed) cnt <= '0;
      else if (tick_us) cnt <= cnt + 1'b1;
      if (st == S_REST) wake_pend <= 1'b0;
      else if (in_down && wake_req) wake_pend <= 1'b1;
      case (st)
        S_REST: if (go) begin
          if (!slp_deep_n) slp_deep_n <= 1'b1;
          else if (!slp_mid_n) slp_mid_n <= 1'b1;
          else slp_light_n <= 1'b1;
        end
        W_MID:   if (hit) slp_mid_n <= 1'b1;
        W_LIGHT: if (hit) slp_light_n <= 1'b1;
        W_CLK:   if (hit) begin clk_valid <= 1'b1; cpu_pwrgd <= 1'b1; end
        W_SUS:   if (st_n == W_RST) sus_stat_n <= 1'b1;
        W_RST:   if (hit) plt_rst_n <= 1'b1;
        S_ON:    if (sleep_req) depth <= sleep_depth;
        D_SUS:   if (hit) sus_stat_n <= 1'b0;
        D_RST:   if (hit) plt_rst_n <= 1'b0;
        D_PG:    if (hit) cpu_pwrgd <= 1'b0;
        D_CLK:   if (hit) clk_valid <= 1'b0;
        D_LIGHT: if (hit) slp_light_n <= 1'b0;
        D_MID:   if (hit) slp_mid_n <= 1'b0;
        D_DEEP:  if (hit) slp_deep_n <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sys_pwrok,
  input logic slp_deep_n,
  input logic slp_mid_n,
  input logic slp_light_n,
  input logic sus_stat_n,
  input logic plt_rst_n,
  input logic cpu_pwrgd,
  input logic clk_valid
);
  p_reset_state_r1: assert property (@(posedge clk) !rst_n |=>
    (!slp_deep_n && !slp_mid_n && !slp_light_n && !sus_stat_n && !plt_rst_n && !cpu_pwrgd && !clk_valid));
  p_mid_after_deep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slp_mid_n) |-> slp_deep_n);
  p_light_after_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slp_light_n) |-> slp_mid_n);
  p_clk_needs_awake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_valid) |-> (slp_light_n && slp_mid_n && slp_deep_n && cpu_pwrgd));
  p_sus_needs_pg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus_stat_n) |-> (cpu_pwrgd && $past(sys_pwrok)));
  p_rst_after_sus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plt_rst_n) |-> sus_stat_n);
  p_rst_fall_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(plt_rst_n) |-> !sus_stat_n);
  p_pg_fall_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_pwrgd) |-> !plt_rst_n);
  p_clk_fall_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_valid) |-> !cpu_pwrgd);
  p_light_fall_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp_light_n) |-> !clk_valid);
  p_mid_fall_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp_mid_n) |-> !slp_light_n);
  p_deep_fall_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp_deep_n) |-> !slp_mid_n);
endmodule

bind sleep_seq sleep_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_pwrok(sys_pwrok),
  .slp_deep_n(slp_deep_n), .slp_mid_n(slp_mid_n), .slp_light_n(slp_light_n),
  .sus_stat_n(sus_stat_n), .plt_rst_n(plt_rst_n), .cpu_pwrgd(cpu_pwrgd), .clk_valid(clk_valid)
);

// File: tb/sleep_seq_bench.sv
module sleep_seq_bench;
  localparam int TD = 4;
  localparam int T_SLP = 3, T_DEGL = 5, T_CLK = 4, T_SUS = 4, T_PLT = 2;
  localparam int T_IDLE = 2, T_SUSRST = 6, T_PGOFF = 3, T_CLKOFF = 2, T_LIGHT = 1;

  logic clk = 0, rst_n = 0, tick_us = 0, wake_req = 0, sleep_req = 0;
  logic [1:0] sleep_depth = 2'd3;
  logic links_idle = 0, pwrok_raw = 0, sys_pwrok = 0;
  logic slp_deep_n, slp_mid_n, slp_light_n, sus_stat_n, plt_rst_n, cpu_pwrgd, clk_valid;
  int errors = 0, checks = 0, cyc = 0, tdiv = 0;

  always #5 clk = ~clk;

  sleep_seq #(.T_SLP(T_SLP), .T_DEGL(T_DEGL), .T_CLK(T_CLK), .T_SUS(T_SUS), .T_PLT(T_PLT),
    .T_IDLE(T_IDLE), .T_SUSRST(T_SUSRST), .T_PGOFF(T_PGOFF), .T_CLKOFF(T_CLKOFF), .T_LIGHT(T_LIGHT))
  u_sleep_seq (.clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wake_req(wake_req), .sleep_req(sleep_req),
    .sleep_depth(sleep_depth), .links_idle(links_idle), .pwrok_raw(pwrok_raw), .sys_pwrok(sys_pwrok),
    .slp_deep_n(slp_deep_n), .slp_mid_n(slp_mid_n), .slp_light_n(slp_light_n), .sus_stat_n(sus_stat_n),
    .plt_rst_n(plt_rst_n), .cpu_pwrgd(cpu_pwrgd), .clk_valid(clk_valid));

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TD;
    tick_us = (tdiv == 0);
  end

  // behavioural reference: phase number, ticks left in the current wait
  int ph, left, pgc, dep;
  bit pend;
  bit e_d, e_m, e_l, e_s, e_r, e_p, e_c;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; left = 0; pgc = 0; dep = 3; pend = 0;
      {e_d, e_m, e_l, e_s, e_r, e_p, e_c} = '0;
    end else begin
      automatic int old = ph;
      automatic bit pg_good = (pgc == T_DEGL);
      automatic bit go = wake_req || pend;
      automatic bit fire = 0;
      automatic bit light_was = e_l;
      if (left > 0 && tick_us) begin
        left = left - 1;
        fire = (left == 0);
      end
      case (old)
        0: if (go) begin
             if (!e_d) begin e_d = 1; ph = 1; left = T_SLP; end
             else if (!e_m) begin e_m = 1; ph = 2; left = T_SLP; end
             else begin e_l = 1; ph = 3; end
           end
        1: if (fire) begin e_m = 1; ph = 2; left = T_SLP; end
        2: if (fire) begin e_l = 1; ph = 3; end
        3: if (pg_good) begin ph = 4; left = T_CLK; end
        4: if (fire) begin e_c = 1; e_p = 1; ph = 5; end
        5: if (sys_pwrok) begin ph = 6; left = T_SUS; end
        6: if (!sys_pwrok) begin ph = 5; left = 0; end
           else if (fire) begin e_s = 1; ph = 7; left = T_PLT; end
        7: if (fire) begin e_r = 1; ph = 8; end
        8: if (sleep_req) begin dep = sleep_depth; ph = 9; end
        9: if (links_idle) begin ph = 10; left = T_IDLE; end
        10: if (fire) begin e_s = 0; ph = 11; left = T_SUSRST; end
        11: if (fire) begin e_r = 0; ph = 12; left = T_PGOFF; end
        12: if (fire) begin e_p = 0; ph = 13; left = T_CLKOFF; end
        13: if (fire) begin e_c = 0; ph = 14; left = T_LIGHT; end
        14: if (fire) begin e_l = 0; if (dep < 2) ph = 0; else begin ph = 15; left = T_SLP; end end
        15: if (fire) begin e_m = 0; if (dep == 2) ph = 0; else begin ph = 16; left = T_SLP; end end
        16: if (fire) begin e_d = 0; ph = 0; end
        default: ;
      endcase
      if (old == 0) pend = 0;
      else if (old >= 9 && wake_req) pend = 1;
      if (!pwrok_raw || !light_was) pgc = 0;
      else if (tick_us && pgc < T_DEGL) pgc = pgc + 1;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R3 sleep enables", {slp_deep_n, slp_mid_n, slp_light_n}, {e_d, e_m, e_l});
    check("R5 clk_valid/cpu_pwrgd", {clk_valid, cpu_pwrgd}, {e_c, e_p});
    check("R6 sus_stat_n", sus_stat_n, e_s);
    check("R7 plt_rst_n", plt_rst_n, e_r);
  end

  function automatic logic outv(input int sel);
    case (sel)
      0: return slp_deep_n;
      1: return slp_mid_n;
      2: return slp_light_n;
      3: return sus_stat_n;
      4: return plt_rst_n;
      default: return clk_valid;
    endcase
  endfunction

  task automatic wait_out(input int sel, input logic val, input string tag);
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (outv(sel) == val) begin
        check(tag, 1, 1);
        return;
      end
    end
    check(tag, outv(sel), val);
  endtask

  task automatic pulse_wake();
    @(negedge clk) wake_req = 1;
    @(negedge clk) wake_req = 0;
  endtask

  task automatic pulse_sleep(input logic [1:0] d);
    @(negedge clk) begin sleep_req = 1; sleep_depth = d; end
    @(negedge clk) sleep_req = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    int g;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset outputs", {slp_deep_n, slp_mid_n, slp_light_n, sus_stat_n, plt_rst_n, cpu_pwrgd, clk_valid}, 0);
    pwrok_raw = 1;
    // R2: deepest released first, middle still asserted
    @(negedge clk) wake_req = 1;
    @(negedge clk) wake_req = 0;
    check("R2 deep first", {slp_deep_n, slp_mid_n, slp_light_n}, 3'b100);
    wait_out(2, 1'b1, "R3 light released");
    repeat (3 * TD) @(negedge clk);
    pwrok_raw = 0;
    @(negedge clk) pwrok_raw = 1;
    g = cyc;
    wait_out(5, 1'b1, "R4 clk_valid after deglitch");
    check("R4 glitch restarts count", (cyc - g) >= (T_DEGL + T_CLK - 1) * TD, 1);
    pulse_sleep(2'd1);
    links_idle = 1;
    repeat (10) @(negedge clk);
    check("R6 waits for sys_pwrok", {sus_stat_n, plt_rst_n}, 0);
    sys_pwrok = 1;
    wait_out(4, 1'b1, "R7 reset released");
    repeat (20 * TD) @(negedge clk);
    check("R13 early sleep ignored", sus_stat_n, 1);
    pulse_wake();
    check("R13 wake ignored when on", {slp_light_n, plt_rst_n}, 2'b11);
    links_idle = 0;
    pulse_sleep(2'd1);
    repeat (10 * TD) @(negedge clk);
    check("R8 waits for link idle", sus_stat_n, 1);
    links_idle = 1;
    wait_out(2, 1'b0, "R9 light asserted");
    check("R9 shutdown outputs", {plt_rst_n, cpu_pwrgd, clk_valid}, 0);
    repeat (10 * TD) @(negedge clk);
    check("R10 depth 1 stops", {slp_deep_n, slp_mid_n, slp_light_n}, 3'b110);
    pulse_wake();
    check("R12 resume from light", slp_light_n, 1);
    wait_out(4, 1'b1, "R7 up again");
    pulse_sleep(2'd2);
    wait_out(3, 1'b0, "R8 sus asserted");
    pulse_wake();
    wait_out(1, 1'b0, "R11 shutdown completes");
    check("R10 depth 2 keeps deep", slp_deep_n, 1);
    wait_out(1, 1'b1, "R11 held wake runs");
    wait_out(4, 1'b1, "R12 wake from middle");
    pulse_sleep(2'd3);
    wait_out(0, 1'b0, "R10 full off");
    repeat (20 * TD) @(negedge clk);
    check("R10 rests at full off", {slp_deep_n, slp_mid_n, slp_light_n, plt_rst_n}, 0);
    pulse_wake();
    wait_out(4, 1'b1, "R7 full wake");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule